// File: doc/BRIEF.md
# Nanosecond Time-of-Day Counter

This block keeps a free-running time-of-day value for precision time protocol hardware. The value counts whole nanoseconds in 64 bits, so it never needs wrap handling. Below it sits a 32-bit fraction of a nanosecond. On every enabled clock cycle the block adds a per-tick step to the combined 96-bit value. The step is a fixed-point number with 32 fraction bits. A link-speed code scales the step, and one code stops the clock entirely.

Software reaches the block through a small 32-bit register port. The 64-bit time and the 64-bit step are each split into a lower and an upper word. Two access rules make the split words behave as single 64-bit values. Reading the lower time word freezes a copy of the upper word, which a later read of the upper word returns. A lower word that is written waits in a holding register. The holding register and the upper word are applied together when the upper word is written.

Top module: `ns_time_counter`

## Requirements
- R1: While counting is enabled, every clock edge adds the effective step to the 96-bit value (64 integer bits, 32 fraction bits). The time word shows only the integer part, and fraction carries reach it.
- R2: A read at address 1 returns the current lower 32 time bits and captures the upper 32 bits at that edge. A read at address 2 returns that captured word, even if the live upper word has since changed.
- R3: A write at address 1 alone leaves the running time unchanged.
- R4: A write at address 2 sets the time to {written word, held lower word} on that edge and clears the fraction to zero.
- R5: If a time commit and an enabled tick fall on the same edge, the commit wins and no step is added on that edge.
- R6: The programmed step is written as a lower half (address 3) and an upper half (address 4). It changes only when address 4 is written, and reads of addresses 3 and 4 return the committed step.
- R7: Control bit 1 selects the built-in step 0x01_9999_9999 (1.6 ns) in place of the programmed step.
- R8: The link-speed input scales the selected step. Code 0 multiplies by 1, code 1 by 2, code 2 by 20, and code 3 by 0, which halts the time.
- R9: Control bit 0 enables counting. After reset the time, fraction, step and control register are all zero.
- R10: The control register sits at address 0 and reads back its two bits. Unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| link_speed | input | 2 | Step multiplier code (0:x1, 1:x2, 2:x20, 3:stop) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| time_ns | output | 64 | Live integer nanosecond time |

## Verification
A write of the upper time word and an enabled increment can land on the same clock edge. The bench provokes this by turning counting on and then committing a new time on the very next edge, while the step is 16 ns. The read-back must match the written time plus exactly one step, which comes from the following edge. If the tick had also applied on the commit edge, the value would be one step too high.

// File: rtl/ns_time_counter.sv
module ns_time_counter #(
  parameter int          AW        = 3,
  parameter logic [63:0] BASE_STEP = 64'h0000_0001_9999_9999,
  parameter int          MID_MULT  = 2,
  parameter int          SLOW_MULT = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    link_speed,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic [63:0]   time_ns
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_TLO  = AW'(1);
  localparam logic [AW-1:0] A_THI  = AW'(2);
  localparam logic [AW-1:0] A_SLO  = AW'(3);
  localparam logic [AW-1:0] A_SHI  = AW'(4);

  logic [95:0] acc;
  logic [63:0] step_q;
  logic [31:0] hold_t, hold_s, snap_hi;
  logic [1:0]  ctrl;
  logic [63:0] mult, src_step, eff_step;
  logic        commit_t, run;

  assign commit_t = reg_wr && reg_addr == A_THI;
  assign run      = ctrl[0];
  assign src_step = ctrl[1] ? BASE_STEP : step_q;
  assign time_ns  = acc[95:32];

  always_comb begin
    case (link_speed)
      2'd0:    mult = 64'd1;
      2'd1:    mult = 64'(MID_MULT);
      2'd2:    mult = 64'(SLOW_MULT);
      default: mult = 64'd0;
    endcase
  end

  assign eff_step = src_step * mult;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      step_q  <= '0;
      hold_t  <= '0;
      hold_s  <= '0;
      snap_hi <= '0;
      ctrl    <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) ctrl   <= reg_wdata[1:0];
      if (reg_wr && reg_addr == A_TLO)  hold_t <= reg_wdata;
      if (reg_wr && reg_addr == A_SLO)  hold_s <= reg_wdata;
      if (reg_wr && reg_addr == A_SHI)  step_q <= {reg_wdata, hold_s};
      if (reg_rd && reg_addr == A_TLO)  snap_hi <= acc[95:64];
      if (commit_t)  acc <= {reg_wdata, hold_t, 32'h0};
      else if (run)  acc <= acc + {32'h0, eff_step};
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {30'h0, ctrl};
      A_TLO:   reg_rdata = acc[63:32];
      A_THI:   reg_rdata = snap_hi;
      A_SLO:   reg_rdata = step_q[31:0];
      A_SHI:   reg_rdata = step_q[63:32];
      default: reg_rdata = '0;
    endcase
  end

  p_tick_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !commit_t) |=> acc == $past(acc) + {32'h0, $past(eff_step)});

  p_snap_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_TLO) |=> snap_hi == $past(time_ns[63:32]));

  p_lo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_TLO && !run) |=> $stable(time_ns));

  p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_t |=> (time_ns == {$past(reg_wdata), $past(hold_t)} && acc[31:0] == 32'h0));

  p_step_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_SLO) |=> $stable(step_q));

  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_speed == 2'd3 && !commit_t) |=> $stable(acc));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !commit_t) |=> $stable(acc));
endmodule

// File: tb/ns_time_counter_tb.sv
module ns_time_counter_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  link_speed = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [63:0] time_ns;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  always #5 clk = ~clk;

  ns_time_counter u_dut (
    .clk(clk), .rst_n(rst_n), .link_speed(link_speed),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_ns(time_ns));

  always @(negedge clk) begin
    if (reg_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: actual %h expected none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    reg_rd = 1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic set_time(input logic [63:0] v);
    wr(3'd1, v[31:0]);
    wr(3'd2, v[63:32]);
  endtask

  task automatic set_step(input logic [63:0] v);
    wr(3'd3, v[31:0]);
    wr(3'd4, v[63:32]);
  endtask

  task automatic run_ticks(input int n, input logic [1:0] mode);
    wr(3'd0, {30'h0, mode | 2'b01});
    repeat (n - 1) @(posedge clk);
    #1;
    wr(3'd0, {30'h0, mode & 2'b10});
  endtask

  task automatic rd_time(input logic [63:0] e, input string t);
    rd(3'd1, e[31:0], t);
    rd(3'd2, e[63:32], t);
  endtask

  initial begin
    logic [95:0] x;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    rd(3'd0, 32'h0, "R9 reset ctrl");
    rd_time(64'h0, "R9 reset time");
    rd(3'd3, 32'h0, "R9 reset step lo");
    rd(3'd4, 32'h0, "R9 reset step hi");
    rd(3'd5, 32'h0, "R10 unused addr");

    wr(3'd1, 32'h1234_5678);
    rd_time(64'h0, "R3 lo write alone");
    wr(3'd2, 32'h0000_00AB);
    rd_time(64'hAB_1234_5678, "R4 commit");
    repeat (5) @(posedge clk);
    #1;
    rd_time(64'hAB_1234_5678, "R9 disabled hold");

    wr(3'd3, 32'h8000_0000);
    rd(3'd3, 32'h0, "R6 step lo pending");
    wr(3'd4, 32'h3);
    rd(3'd3, 32'h8000_0000, "R6 step lo");
    rd(3'd4, 32'h3, "R6 step hi");

    set_time(64'd100);
    run_ticks(10, 2'b00);
    rd_time(64'd135, "R1 ten ticks");
    run_ticks(1, 2'b00);
    rd_time(64'd138, "R1 half fraction");
    run_ticks(1, 2'b00);
    rd_time(64'd142, "R1 fraction carry");

    set_time(64'd0);
    run_ticks(1, 2'b00);
    set_time(64'd10);
    run_ticks(1, 2'b00);
    rd_time(64'd13, "R4 fraction cleared");

    set_step(64'h10_0000_0000);
    set_time(64'h1_FFFF_FFF0);
    wr(3'd0, 32'h1);
    rd(3'd1, 32'hFFFF_FFF0, "R2 live low");
    rd(3'd2, 32'h1, "R2 snapshot hi");
    wr(3'd0, 32'h0);
    rd_time(64'h2_0000_0020, "R2 after run");

    wr(3'd1, 32'h1000);
    wr(3'd0, 32'h1);
    wr(3'd2, 32'h5);
    wr(3'd0, 32'h0);
    rd_time(64'h5_0000_1010, "R5 commit beats tick");

    set_time(64'd0);
    run_ticks(5, 2'b10);
    x = 96'(64'h1_9999_9999) * 96'd5;
    rd_time(x[95:32], "R7 default step");
    rd(3'd0, 32'h2, "R10 ctrl readback");
    wr(3'd0, 32'h0);

    link_speed = 2'd1;
    set_time(64'd0);
    run_ticks(5, 2'b10);
    x = 96'(64'h1_9999_9999) * 96'd10;
    rd_time(x[95:32], "R8 mid x2");

    link_speed = 2'd2;
    set_time(64'd0);
    run_ticks(3, 2'b10);
    x = 96'(64'h1_9999_9999) * 96'd60;
    rd_time(x[95:32], "R8 slow x20");

    link_speed = 2'd1;
    set_time(64'd7);
    run_ticks(4, 2'b00);
    rd_time(64'd135, "R8 programmed step x2");

    link_speed = 2'd3;
    set_time(64'd77);
    run_ticks(6, 2'b10);
    rd_time(64'd77, "R8 stopped");
    link_speed = 2'd0;

    @(posedge clk); #1;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule